// File: doc/BRIEF.md
# Home Core Resolution Unit

In a multicore where each physical address may be cached by exactly one core, every data access first has to find that address's home core. This unit takes one access at a time (physical address, requesting thread ID and the core the thread is running on) and answers with either a core hit, meaning the local cache hierarchy may serve the access, or a core miss with the ID of the core the thread must migrate to before it may retry.

Two placement policies are available, chosen by a plain mode pin. In striped placement, 4 KB pages are dealt out round-robin over the cores. In first-touch placement, a small associative table binds a page to the home core of the first thread that touches it, and that binding holds until reset. Each thread's home core comes from a per-thread register table that is loaded through a simple write port before use.

Requests enter through a valid/ready handshake and responses leave through another. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The response sits in one output register: `req_ready` is high whenever that register is empty or is being drained in the same cycle. A response is held, unchanged, for as long as `rsp_valid` is high and `rsp_ready` is low. A request that is not accepted has no effect on any state.

Top module: `home_core_resolver`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit` and `rsp_miss` are low, `req_ready` is high, every thread's home core is 0 and no page is bound in the first-touch table.
- R2: With `mode` = 0 (striped), the home core is the page number (address bits from bit 12 upward) modulo `NUM_CORES`; page `NUM_CORES` wraps to core 0 and the offset bits 11:0 have no effect.
- R3: When the home core equals the `cur_core` sampled with the request, the response has `rsp_hit` = 1, `rsp_miss` = 0 and `rsp_dest` = that core.
- R4: When the home core differs from `cur_core`, the response has `rsp_miss` = 1, `rsp_hit` = 0 and `rsp_dest` = the home core, which is the migration target.
- R5: With `mode` = 1 (first-touch), an accepted access to an unbound page binds it to the requesting thread's programmed home core, and the same response already reports that core.
- R6: A bound page keeps its core until reset, whatever thread later accesses it and even if the binding thread's home core is reprogrammed.
- R7: The response for a request accepted at clock edge k is valid from edge k on; with `rsp_ready` high and no new request it drops after edge k+1.
- R8: While `rsp_valid` = 1 and `rsp_ready` = 0, the response stays stable and `req_ready` is 0; a request offered then is not accepted and binds nothing.
- R9: When all `FT_ENTRIES` table entries are bound, an access to an unbound page in first-touch mode gets the striped home core and creates no binding.
- R10: Accesses in striped mode never create first-touch bindings.
- R11: While `rsp_valid` is high exactly one of `rsp_hit` and `rsp_miss` is high; while it is low both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Placement policy: 0 striped, 1 first-touch |
| cfg_we | input | 1 | Write strobe for the thread home table |
| cfg_thread | input | THREAD_W | Thread whose home core is written |
| cfg_core | input | CORE_W | Home core value written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Physical address of the access |
| req_thread | input | THREAD_W | Requesting thread ID |
| cur_core | input | CORE_W | Core the thread currently runs on |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_hit | output | 1 | Access may be served locally |
| rsp_miss | output | 1 | Thread must migrate to `rsp_dest` |
| rsp_dest | output | CORE_W | Home core of the accessed address |

## Verification
The bench aims at the stripe wrap at page `NUM_CORES` and at offset bits inside a page; a design that took the core index from the wrong bits would send those accesses to the wrong core. It checks that a first-touch binding survives accesses by other threads and a reprogrammed home core, where a design that re-derived the home each time would return a new core. It offers a request during a stalled response, which a design that ignored back-pressure would drop or bind early, and it fills the table to prove that an overflow page falls back to striping rather than overwriting a live entry. Striped accesses made before any first-touch traffic show that striping leaves the table untouched.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic {
    MAP_STRIPED     = 1'b0,
    MAP_FIRST_TOUCH = 1'b1
  } map_mode_e;
endpackage

// File: rtl/hcr_thread_home.sv
module hcr_thread_home #(
  parameter int NUM_THREADS = 8,
  parameter int CORE_W      = 4,
  localparam int THREAD_W   = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [THREAD_W-1:0] wr_thread,
  input  logic [CORE_W-1:0]   wr_core,
  input  logic [THREAD_W-1:0] rd_thread,
  output logic [CORE_W-1:0]   rd_core
);
  logic [CORE_W-1:0] home_q [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) home_q[t] <= '0;
      else if (wr_en && (wr_thread == THREAD_W'(t))) home_q[t] <= wr_core;
    end
  end

  always_comb begin
    rd_core = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (rd_thread == THREAD_W'(t)) rd_core = home_q[t];
  end
endmodule

// File: rtl/hcr_stripe_map.sv
module hcr_stripe_map #(
  parameter int PN_W      = 20,
  parameter int NUM_CORES = 16,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic [PN_W-1:0]   page,
  output logic [CORE_W-1:0] core
);
  if ((NUM_CORES & (NUM_CORES - 1)) == 0) begin : g_pow2
    logic [PN_W-1:0] rem;
    assign rem  = page & PN_W'(NUM_CORES - 1);
    assign core = rem[CORE_W-1:0];
  end else begin : g_mod
    logic [PN_W-1:0] rem;
    assign rem  = page % PN_W'(NUM_CORES);
    assign core = rem[CORE_W-1:0];
  end
endmodule

// File: rtl/hcr_page_binder.sv
module hcr_page_binder #(
  parameter int PN_W       = 20,
  parameter int CORE_W     = 4,
  parameter int FT_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PN_W-1:0]   look_page,
  input  logic [CORE_W-1:0] thread_home,
  input  logic [CORE_W-1:0] fallback_home,
  input  logic              bind_en,
  output logic [CORE_W-1:0] home,
  output logic              mapped,
  output logic              full
);
  logic [FT_ENTRIES-1:0] valid_q;
  logic [PN_W-1:0]       tag_q  [FT_ENTRIES];
  logic [CORE_W-1:0]     core_q [FT_ENTRIES];

  logic [CORE_W-1:0] found_core;
  logic [FT_ENTRIES-1:0] free_oh;

  always_comb begin
    mapped     = 1'b0;
    found_core = '0;
    for (int i = 0; i < FT_ENTRIES; i++) begin
      if (valid_q[i] && tag_q[i] == look_page) begin
        mapped     = 1'b1;
        found_core = found_core | core_q[i];
      end
    end
  end

  always_comb begin
    logic taken;
    taken   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < FT_ENTRIES; i++) begin
      if (!valid_q[i] && !taken) begin
        free_oh[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  assign full = &valid_q;
  assign home = mapped ? found_core : (full ? fallback_home : thread_home);

  for (genvar i = 0; i < FT_ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        core_q[i]  <= '0;
      end else if (bind_en && free_oh[i]) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= look_page;
        core_q[i]  <= thread_home;
      end
    end

    // R6: once bound, an entry never changes until reset
    assert_binding_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[i] |=> (valid_q[i] && $stable(tag_q[i]) && $stable(core_q[i])));
  end

  // R9: no binding is requested while the table is full or the page is present
  assert_no_bind_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bind_en |-> (!full && !mapped));

  // R5: a binding makes the page present on the next cycle
  assert_bind_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bind_en |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
endmodule

// File: rtl/home_core_resolver.sv
module home_core_resolver #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int NUM_CORES   = 16,
  parameter int NUM_THREADS = 8,
  parameter int FT_ENTRIES  = 4,
  localparam int CORE_W     = $clog2(NUM_CORES),
  localparam int THREAD_W   = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int PN_W       = ADDR_W - PAGE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic                cfg_we,
  input  logic [THREAD_W-1:0] cfg_thread,
  input  logic [CORE_W-1:0]   cfg_core,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [THREAD_W-1:0] req_thread,
  input  logic [CORE_W-1:0]   cur_core,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [CORE_W-1:0]   rsp_dest
);
  import hcr_pkg::*;

  map_mode_e         mode_e;
  logic [PN_W-1:0]   page;
  logic [CORE_W-1:0] thread_home, stripe_home, ft_home, home_now;
  logic              ft_mapped, ft_full, accept, bind_en;

  logic              rsp_valid_q, rsp_hit_q;
  logic [CORE_W-1:0] rsp_dest_q;

  assign mode_e = map_mode_e'(mode);
  assign page   = req_addr[ADDR_W-1:PAGE_BITS];

  hcr_thread_home #(.NUM_THREADS(NUM_THREADS), .CORE_W(CORE_W)) u_homes (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_thread(cfg_thread), .wr_core(cfg_core),
    .rd_thread(req_thread), .rd_core(thread_home)
  );

  hcr_stripe_map #(.PN_W(PN_W), .NUM_CORES(NUM_CORES)) u_stripe (
    .page(page), .core(stripe_home)
  );

  hcr_page_binder #(.PN_W(PN_W), .CORE_W(CORE_W), .FT_ENTRIES(FT_ENTRIES)) u_binder (
    .clk(clk), .rst_n(rst_n),
    .look_page(page), .thread_home(thread_home), .fallback_home(stripe_home),
    .bind_en(bind_en), .home(ft_home), .mapped(ft_mapped), .full(ft_full)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign bind_en   = accept && (mode_e == MAP_FIRST_TOUCH) && !ft_mapped && !ft_full;
  assign home_now  = (mode_e == MAP_FIRST_TOUCH) ? ft_home : stripe_home;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_dest_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= (home_now == cur_core);
      rsp_dest_q  <= home_now;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_valid_q && rsp_hit_q;
  assign rsp_miss  = rsp_valid_q && !rsp_hit_q;
  assign rsp_dest  = rsp_dest_q;

  // R11: exactly one verdict with a response, none without
  assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));
  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss));

  // R8: a stalled response is held and blocks new requests
  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dest) && $stable(rsp_hit)));
  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R7: an accepted request yields a response on the next cycle
  assert_one_cycle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10: striped mode never binds pages
  assert_striped_no_bind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MAP_STRIPED) |-> !bind_en);
endmodule

// File: tb/home_core_resolver_test.sv
module home_core_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_thread = '0;
  logic [3:0] cfg_core = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0] req_thread = '0;
  logic [3:0] cur_core = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic       rsp_hit, rsp_miss;
  logic [3:0] rsp_dest;

  int n_checks = 0;
  int n_fail = 0;

  home_core_resolver #(.NUM_CORES(NC), .NUM_THREADS(8), .FT_ENTRIES(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cfg_we(cfg_we), .cfg_thread(cfg_thread), .cfg_core(cfg_core),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_thread(req_thread), .cur_core(cur_core),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_dest(rsp_dest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_home(input int thr, input int core);
    @(negedge clk); cfg_we = 1'b1; cfg_thread = 3'(thr); cfg_core = 4'(core);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // one accepted request; checks dest and verdict at the following negedge
  task automatic do_req(input string req, input logic [31:0] a, input int thr,
                        input int cur, input int exp_dest);
    @(negedge clk);
    req_addr = a; req_thread = 3'(thr); cur_core = 4'(cur); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " dest"}, int'(rsp_dest), exp_dest);
    check({req, " hit"}, int'(rsp_hit), (exp_dest == cur) ? 1 : 0);
    check({req, " miss R4/R11"}, int'(rsp_miss), (exp_dest == cur) ? 0 : 1);
  endtask

  task automatic t_reset_R1();
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 verdict", int'(rsp_hit | rsp_miss), 0);
  endtask

  task automatic t_striped_R2();
    mode = 1'b0;
    do_req("R2/R3 page3 hit", 32'h0000_3000, 0, 3, 3);
    do_req("R2/R4 page5 miss", 32'h0000_5abc, 0, 3, 5);
    do_req("R2 wrap page16", 32'h0001_0000, 0, 3, 0);
    do_req("R2 offset ignored", 32'h0000_3fff, 0, 3, 3);
    do_req("R2 page 0x2f", 32'h0002_f123, 0, 15, 15);
  endtask

  task automatic t_latency_R7();
    @(negedge clk);
    req_addr = 32'h0000_7000; req_thread = 0; cur_core = 0; req_valid = 1'b1;
    check("R7 idle before accept", int'(rsp_valid), 0);
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    check("R7 valid after accept", int'(rsp_valid), 1);
    @(negedge clk);
    check("R7 drops after drain", int'(rsp_valid), 0);
  endtask

  task automatic t_first_touch_R5();
    set_home(0, 7); set_home(1, 2); set_home(2, 9); set_home(3, 11);
    mode = 1'b1;
    // R10: page 5 was touched in striped mode and must still be unbound
    do_req("R10/R5 page5 binds to thread1 home", 32'h0000_5000, 1, 2, 2);
    do_req("R6 other thread keeps binding", 32'h0000_5010, 0, 7, 2);
    set_home(1, 13);
    do_req("R6 reprogrammed home ignored", 32'h0000_5020, 1, 13, 2);
    do_req("R5 page 0x40 binds to 7", 32'h0004_0000, 0, 7, 7);
  endtask

  task automatic t_backpressure_R8();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 32'h0005_0000; req_thread = 2; cur_core = 9; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_addr = 32'h0006_0000; req_thread = 0; cur_core = 0;
    check("R8 stalled valid", int'(rsp_valid), 1);
    check("R8 stalled dest", int'(rsp_dest), 9);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R8 req_ready low", int'(req_ready), 0);
      check("R8 dest stable", int'(rsp_dest), 9);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", int'(rsp_valid), 0);
    // page 0x60 was offered during the stall by thread0 (home 7): it must be unbound
    do_req("R8 stalled request bound nothing", 32'h0006_0000, 3, 11, 11);
  endtask

  task automatic t_full_R9();
    // table now holds pages 5, 0x40, 0x50, 0x60
    do_req("R9 full falls back to stripe", 32'h0007_1000, 2, 1, 1);
    do_req("R9 no binding made", 32'h0007_1000, 3, 11, 1);
    do_req("R6 earlier binding intact", 32'h0005_0000, 3, 11, 9);
  endtask

  task automatic t_reset_clears_R1();
    do_reset();
    t_reset_R1();
    set_home(3, 11);
    mode = 1'b1;
    do_req("R1 table empty after reset", 32'h0000_5000, 3, 11, 11);
    do_req("R1 thread homes cleared", 32'h0008_0000, 4, 0, 0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset_R1();
        t_striped_R2();
        t_latency_R7();
        t_first_touch_R5();
        t_backpressure_R8();
        t_full_R9();
        t_reset_clears_R1();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule